// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block gathers the pending indications of a large set of general-purpose pins and turns them into one interrupt request for the processor. Every pin has two status inputs, an interrupt status and a wake status. The pin counts as pending while either of them is set. Pins are taken in groups of four consecutive pins, and each group sets one summary bit. The summary bits are laid out across two 32-bit read-only words, and software reads them to find which groups need service.

The summary has no acknowledge of its own. A summary bit falls as soon as the pins of its group stop pending. The interrupt line has a gate. Once the line is raised it stays raised, and no further interrupt is produced, until software writes the end-of-interrupt bit in the control word. If any summary bit is still set after that write, the line rises again on the following cycle. With the default of 184 pins, summary bits 0 to 45 carry information and the remaining bits of the high word read as zero.

Top module: `irq_group_aggregator`

## Requirements
- R1: Summary bit n equals the OR of the pending state of pins 4n, 4n+1, 4n+2 and 4n+3. It is registered, so it is visible one clock after the pin inputs change.
- R2: A pin is pending when its interrupt status input or its wake status input is 1. Either input alone is enough.
- R3: A read at address 0 returns summary bits 0 to 31 in data bits 0 to 31. A read at address 1 returns summary bits 32 to 63 in data bits 0 to 31. Summary bits 46 to 63 always read as 0.
- R4: A summary bit returns to 0 one clock after all four pins of its group stop pending. No register access is needed for this.
- R5: While no interrupt is outstanding, `irq_o` rises on the clock edge after the summary becomes non-zero. That is two edges after a pin starts pending.
- R6: Once `irq_o` is high it stays high, even if the summary clears, until an end-of-interrupt write arrives.
- R7: An end-of-interrupt write is a write to address 2 with data bit 0 set. It drives `irq_o` low on that clock edge. On the next edge `irq_o` rises again if the summary is still non-zero, and otherwise it stays low.
- R8: The end-of-interrupt bit clears itself. Address 2 always reads as 0, and a write to address 2 with data bit 0 clear has no effect on `irq_o`.
- R9: Writes to addresses 0 and 1 are ignored. They change neither the summary read back nor `irq_o`. Address 3 reads as 0.
- R10: While `rst_n` is low, `irq_o` is 0 and both summary words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_irq_sts | input | NUM_PINS (184) | Interrupt status of each pin |
| pin_wake_sts | input | NUM_PINS (184) | Wake status of each pin |
| reg_addr | input | ADDR_W (2) | Register address: 0 low summary, 1 high summary, 2 control |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | WORD_W (32) | Write data; bit 0 is end-of-interrupt |
| reg_rdata | output | WORD_W (32) | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench drives every pin one at a time. Pins alternate between the interrupt and the wake input. For each pin it checks the single expected summary bit in the expected word and that the other word reads as zero, which separates group indexing errors from word-split errors. The bench also walks all fifteen non-zero patterns of the partial top group, so a group that dropped one member would show up. It then sets every pin at once to check the padding bits of the high word. The gate is checked by clearing the pins while the line is held, by writing end-of-interrupt with the summary both cleared and still set, and by writing to the control word with the end-of-interrupt bit clear and to the read-only words.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   // State of the interrupt gate
   typedef enum logic {
      GATE_IDLE = 1'b0,
      GATE_BUSY = 1'b1
   } gate_state_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/irqagg_group_reduce.sv
module irqagg_group_reduce #(
   parameter int NUM_PINS   = 184,
   parameter int GROUP_SIZE = 4,
   parameter int SUM_W      = 64,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_sts,
   input  logic [NUM_PINS-1:0] wake_sts,
   output logic [SUM_W-1:0]    sum_o
);
   localparam int NUM_GROUPS = irqagg_pkg::ceil_div(NUM_PINS, GROUP_SIZE);
   localparam int PAD_W      = NUM_GROUPS * GROUP_SIZE;

   logic [PAD_W-1:0] pend_pad;
   logic [SUM_W-1:0] sum_c;

   // Pins past NUM_PINS in the last group are padded with 0
   always_comb begin
      pend_pad                 = '0;
      pend_pad[NUM_PINS-1:0]   = irq_sts | wake_sts;
   end

   for (genvar g = 0; g < SUM_W; g++) begin : g_sum
      if (g < NUM_GROUPS) begin : g_live
         assign sum_c[g] = |pend_pad[g*GROUP_SIZE +: GROUP_SIZE];
      end else begin : g_pad
         assign sum_c[g] = 1'b0;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_o <= '0;
         else        sum_o <= sum_c;
      end
   end else begin : g_comb
      assign sum_o = sum_c;
   end
endmodule

// File: rtl/irqagg_irq_gate.sv
module irqagg_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic sum_any,
   input  logic eoi,
   output logic irq_o
);
   import irqagg_pkg::*;

   gate_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (eoi)                                 state_d = GATE_IDLE;
      else if (state_q == GATE_IDLE && sum_any) state_d = GATE_BUSY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GATE_IDLE;
      else        state_q <= state_d;
   end

   assign irq_o = (state_q == GATE_BUSY);
endmodule

// File: rtl/irqagg_reg_port.sv
module irqagg_reg_port #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 2,
   parameter int ADDR_W    = 2,
   parameter int EOI_BIT   = 0
) (
   input  logic [NUM_WORDS*WORD_W-1:0] sum,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_we,
   input  logic [WORD_W-1:0]           reg_wdata,
   output logic [WORD_W-1:0]           reg_rdata,
   output logic                        eoi_o
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);

   // Control word holds no state: the end-of-interrupt request is a one-cycle pulse
   assign eoi_o = reg_we && (reg_addr == CTRL_ADDR) && reg_wdata[EOI_BIT];

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (reg_addr == ADDR_W'(w)) reg_rdata = sum[w*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator #(
   parameter int NUM_PINS   = 184,
   parameter int GROUP_SIZE = 4,
   parameter int WORD_W     = 32,
   parameter int NUM_WORDS  = 2,
   parameter int ADDR_W     = 2,
   parameter int EOI_BIT    = 0,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_irq_sts,
   input  logic [NUM_PINS-1:0] pin_wake_sts,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic                irq_o
);
   localparam int NUM_GROUPS = irqagg_pkg::ceil_div(NUM_PINS, GROUP_SIZE);
   localparam int SUM_W      = NUM_WORDS * WORD_W;

   if (NUM_GROUPS > SUM_W) begin : g_bad_words
      $error("summary words too narrow for the pin groups");
   end
   if (NUM_WORDS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("address width cannot reach the control word");
   end
   if (EOI_BIT >= WORD_W) begin : g_bad_eoi
      $error("end-of-interrupt bit outside the word");
   end

   logic [SUM_W-1:0] sum_q;
   logic             eoi;

   irqagg_group_reduce #(
      .NUM_PINS  (NUM_PINS),
      .GROUP_SIZE(GROUP_SIZE),
      .SUM_W     (SUM_W),
      .REG_OUT   (REG_OUT)
   ) u_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_sts (pin_irq_sts),
      .wake_sts(pin_wake_sts),
      .sum_o   (sum_q)
   );

   irqagg_reg_port #(
      .WORD_W   (WORD_W),
      .NUM_WORDS(NUM_WORDS),
      .ADDR_W   (ADDR_W),
      .EOI_BIT  (EOI_BIT)
   ) u_regs (
      .sum      (sum_q),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .eoi_o    (eoi)
   );

   irqagg_irq_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .sum_any(|sum_q),
      .eoi    (eoi),
      .irq_o  (irq_o)
   );
endmodule

// File: rtl/irq_group_aggregator_chk.sv
module irq_group_aggregator_chk #(
   parameter int NUM_PINS   = 184,
   parameter int GROUP_SIZE = 4,
   parameter int WORD_W     = 32,
   parameter int NUM_WORDS  = 2,
   parameter int ADDR_W     = 2,
   parameter int EOI_BIT    = 0,
   parameter bit REG_OUT    = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_PINS-1:0]           pin_irq_sts,
   input logic [NUM_PINS-1:0]           pin_wake_sts,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic                          reg_we,
   input logic [WORD_W-1:0]             reg_wdata,
   input logic [WORD_W-1:0]             reg_rdata,
   input logic                          irq_o,
   input logic [NUM_WORDS*WORD_W-1:0]   sum_q
);
   localparam int NUM_GROUPS = irqagg_pkg::ceil_div(NUM_PINS, GROUP_SIZE);
   localparam int HI_USED    = NUM_GROUPS - (NUM_WORDS - 1) * WORD_W;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_WORDS);
   localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(NUM_WORDS - 1);

   logic eoi_wr;
   assign eoi_wr = reg_we && (reg_addr == CTRL_A) && reg_wdata[EOI_BIT];

   assert_rise_needs_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(sum_q != '0));

   assert_hold_until_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !eoi_wr) |=> irq_o);

   assert_eoi_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr |=> !irq_o);

   assert_ctrl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CTRL_A) |-> (reg_rdata == '0));

   assert_hi_padding_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == HI_A) |-> ((reg_rdata >> HI_USED) == '0));

   if (REG_OUT) begin : g_reg_checks
      assert_idle_pins_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ((pin_irq_sts | pin_wake_sts) == '0) |=> (sum_q == '0));
   end
endmodule

bind irq_group_aggregator irq_group_aggregator_chk #(
   .NUM_PINS  (NUM_PINS),
   .GROUP_SIZE(GROUP_SIZE),
   .WORD_W    (WORD_W),
   .NUM_WORDS (NUM_WORDS),
   .ADDR_W    (ADDR_W),
   .EOI_BIT   (EOI_BIT),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pin_irq_sts (pin_irq_sts),
   .pin_wake_sts(pin_wake_sts),
   .reg_addr    (reg_addr),
   .reg_we      (reg_we),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .irq_o       (irq_o),
   .sum_q       (sum_q)
);

// File: tb/irq_group_aggregator_bench.sv
module irq_group_aggregator_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP         = 184;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] irq_s;
   logic [NP-1:0] wake_s;
   logic [1:0]    reg_addr;
   logic          reg_we;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_group_aggregator u_irq_group_aggregator (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_irq_sts (irq_s),
      .pin_wake_sts(wake_s),
      .reg_addr    (reg_addr),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq_o       (irq_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] v);
      reg_addr  = a;
      reg_wdata = v;
      reg_we    = 1'b1;
      step();
      reg_we    = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; irq_s = '0; wake_s = '0;
      reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
      repeat (3) step();
      rd(2'd0, d); chk("R10 low word in reset", d, 32'h0);
      chk("R10 irq in reset", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      step();
      rd(2'd1, d); chk("R10 high word after reset", d, 32'h0);

      // Sweep every pin alone, alternating the two status inputs (R1, R2)
      for (int p = 0; p < NP; p++) begin
         int g, w, b;
         g = p / 4; w = g / 32; b = g % 32;
         if (p % 2 == 0) irq_s[p] = 1'b1; else wake_s[p] = 1'b1;
         step();
         rd(2'(w), d);     chk($sformatf("R1 R2 pin %0d own word", p), d, 32'h1 << b);
         rd(2'(1 - w), d); chk($sformatf("R3 pin %0d other word", p), d, 32'h0);
         chk("R5 no irq before gate edge", {31'b0, irq_o}, 32'h0);
         step();
         chk("R5 irq raised", {31'b0, irq_o}, 32'h1);
         irq_s = '0; wake_s = '0;
         step();
         rd(2'(w), d); chk("R4 summary clears with pins", d, 32'h0);
         chk("R6 irq held after clear", {31'b0, irq_o}, 32'h1);
         wr(2'd2, 32'h1);
         chk("R7 eoi drops irq", {31'b0, irq_o}, 32'h0);
         step();
         chk("R7 no reassert when idle", {31'b0, irq_o}, 32'h0);
      end

      // All patterns of the top group (pins 180..183 -> bit 13 of high word)
      for (int v = 1; v < 16; v++) begin
         irq_s[183:180] = 4'(v);
         step();
         rd(2'd1, d); chk($sformatf("R1 top group pattern %0d", v), d, 32'h0000_2000);
         irq_s = '0;
         step();
         rd(2'd1, d); chk("R4 top group clears", d, 32'h0);
      end
      wr(2'd2, 32'h1);
      step();

      // Every pin pending: padding of the high word (R3)
      irq_s = '1;
      step();
      rd(2'd0, d); chk("R3 all pins low word", d, 32'hFFFF_FFFF);
      rd(2'd1, d); chk("R3 all pins high word", d, 32'h0000_3FFF);
      step();
      chk("R5 irq with all pins", {31'b0, irq_o}, 32'h1);
      wr(2'd2, 32'h1);
      chk("R7 eoi drops irq while pending", {31'b0, irq_o}, 32'h0);
      step();
      chk("R7 reassert after eoi", {31'b0, irq_o}, 32'h1);
      wr(2'd2, 32'hFFFF_FFFE);
      chk("R8 write without eoi bit", {31'b0, irq_o}, 32'h1);
      rd(2'd2, d); chk("R8 control reads zero", d, 32'h0);
      wr(2'd0, 32'h0);
      rd(2'd0, d); chk("R9 write low word ignored", d, 32'hFFFF_FFFF);
      wr(2'd1, 32'h0);
      rd(2'd1, d); chk("R9 write high word ignored", d, 32'h0000_3FFF);
      chk("R9 irq unaffected by status write", {31'b0, irq_o}, 32'h1);

      irq_s = '0;
      step();
      wr(2'd2, 32'h1);
      step();
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'hFFFF_FFFF);
      step();
      rd(2'd0, d); chk("R9 low word stays zero", d, 32'h0);
      rd(2'd1, d); chk("R9 high word stays zero", d, 32'h0);
      rd(2'd3, d); chk("R9 unused address reads zero", d, 32'h0);
      chk("R9 no irq from status writes", {31'b0, irq_o}, 32'h0);

      // Reset while active (R10)
      wake_s[7] = 1'b1;
      step(); step();
      chk("R5 irq before reset", {31'b0, irq_o}, 32'h1);
      rst_n = 1'b0;
      #1;
      chk("R10 irq cleared by reset", {31'b0, irq_o}, 32'h0);
      rd(2'd0, d); chk("R10 summary cleared by reset", d, 32'h0);
      step();
      wake_s = '0;
      rst_n  = 1'b1;
      step();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule